// File: doc/BRIEF.md
# Multilevel carry lookahead adder

This block is a combinational two's-complement adder and subtracter. It is built for wide datapaths where a ripple chain of full adders would be too slow. Each bit position forms a carry generate term and a carry propagate term. A tree of lookahead units then combines these terms, each unit taking GROUP inputs. Going up the tree, every unit condenses its inputs into one group generate and one group propagate. Going back down, every unit takes the single carry into its group and returns the carry into each of its members. This gives a carry path whose depth grows with the logarithm of the width to the base GROUP.

A subtract control inverts the second operand and forces a carry of one into bit zero, so the same tree computes the first operand minus the second. The block reports the carry out of the top bit and a signed overflow flag beside the sum. It holds no state, so its outputs follow its inputs within the same time step.

Top module: `cla_adder`

## Requirements
- R1: With `sub_en` low, `{carry_out, sum_out}` equals the unsigned sum `op_a + op_b + carry_in`, computed at WIDTH+1 bits.
- R2: With `sub_en` high, the second operand is bit-inverted and the carry into bit 0 is forced to 1, so `sum_out` equals `op_a - op_b` modulo 2^WIDTH, and `carry_in` has no effect on any output.
- R3: With `sub_en` high, `carry_out` is 1 exactly when `op_a >= op_b` as unsigned numbers, meaning no borrow.
- R4: `ovf_out` is 1 exactly when the effective operands (`op_a`, and `op_b` or its inverse) have equal sign bits (bit WIDTH-1) and the sign bit of `sum_out` differs from them. This equals the true signed result lying outside the WIDTH-bit two's-complement range.
- R5: Every bit forms generate = a AND b and propagate = a OR b, and the carry into bit j+1 is G(j) OR (P(j) AND c(j)). A carry entering an all-propagate operand pair travels across the whole width: all-ones plus zero with carry-in 1 gives sum 0 and carry-out 1.
- R6: At every tree level, a unit's group generate and group propagate satisfy: carry out of the group = group generate OR (group propagate AND carry into the group). The carry the unit hands to each member agrees with rippling the member terms. For alternating-bit operand pairs, the sum is all ones with no carry, or zero with a full-width carry.
- R7: The block is purely combinational: a new input pattern produces its result without any clock edge.
- R8: WIDTH must be 16, 32 or 64, GROUP must be 2 or 4, and WIDTH must be a power of GROUP, or elaboration fails. Both the 64-bit GROUP=4 and the 32-bit GROUP=2 configurations meet R1 to R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand, inverted when subtracting |
| sub_en | input | 1 | 1 selects op_a - op_b, 0 selects op_a + op_b + carry_in |
| carry_in | input | 1 | Carry into bit 0 in add mode; ignored when sub_en is 1 |
| sum_out | output | WIDTH | Sum or difference, modulo 2^WIDTH |
| carry_out | output | 1 | Carry out of bit WIDTH-1 (1 = no borrow when subtracting) |
| ovf_out | output | 1 | Signed overflow flag |

## Verification
The embedded assertions compare the tree against plain wide arithmetic, evaluated whenever the inputs change. They therefore assume every operand and control bit is a known 0 or 1, and that each input pattern stays in place long enough for the whole tree to settle before it is judged. The bench meets both assumptions. It drives only two-state values, changes all inputs of an adder together on the falling clock edge, holds them, and samples the outputs one nanosecond later, well before the next change. Random operands are mixed with biased pairs (equal, complementary, sign-boundary) so that long carry chains and both overflow directions occur in both configurations.

// File: rtl/cla_pkg.sv
package cla_pkg;

   // number of tree levels needed to reduce w bits to a single node
   function automatic int tree_depth(input int w, input int k);
      int n;
      int d;
      n = 1;
      d = 0;
      while (n < w) begin
         n = n * k;
         d = d + 1;
      end
      return d;
   endfunction

   // true when w is an exact power of k
   function automatic bit is_power_of(input int w, input int k);
      int n;
      n = 1;
      while (n < w) n = n * k;
      return (n == w);
   endfunction

   // node count at a given level (level 0 = bit positions)
   function automatic int level_nodes(input int w, input int k, input int lvl);
      int n;
      n = w;
      for (int i = 0; i < lvl; i++) n = n / k;
      return n;
   endfunction

endpackage

// File: rtl/cla_pg_bits.sv
module cla_pg_bits #(
   parameter int WIDTH = 64
) (
   input  logic [WIDTH-1:0] a_bits,
   input  logic [WIDTH-1:0] b_bits,
   output logic [WIDTH-1:0] gen_bits,
   output logic [WIDTH-1:0] prop_bits
);

   for (genvar j = 0; j < WIDTH; j++) begin : bit_pg
      assign gen_bits[j]  = a_bits[j] & b_bits[j];
      assign prop_bits[j] = a_bits[j] | b_bits[j];
   end

   // R5: a bit that generates also propagates (inclusive OR form)
   always_comb begin
      // R5
      pg_cover_chk: assert ((gen_bits & ~prop_bits) == '0)
         else $error("generate set without propagate");
   end

endmodule

// File: rtl/cla_group.sv
module cla_group #(
   parameter int K = 4
) (
   input  logic [K-1:0] g_in,
   input  logic [K-1:0] p_in,
   input  logic         c_in,
   output logic         g_out,
   output logic         p_out,
   output logic [K-1:0] c_child
);

   // Flattened lookahead over members below index 'upto':
   // bit 1 = combined generate, bit 0 = combined propagate.
   function automatic logic [1:0] span_gp(input logic [K-1:0] g,
                                          input logic [K-1:0] p,
                                          input int upto);
      logic acc;
      logic chain;
      acc   = 1'b0;
      chain = 1'b1;
      for (int m = K - 1; m >= 0; m--) begin
         if (m < upto) begin
            acc   = acc | (chain & g[m]);
            chain = chain & p[m];
         end
      end
      return {acc, chain};
   endfunction

   for (genvar i = 0; i < K; i++) begin : carry_tap
      logic [1:0] sp;
      assign sp         = span_gp(g_in, p_in, i);
      assign c_child[i] = sp[1] | (sp[0] & c_in);
   end

   logic [1:0] grp;
   assign grp   = span_gp(g_in, p_in, K);
   assign g_out = grp[1];
   assign p_out = grp[0];

   always_comb begin
      for (int i = 0; i < K - 1; i++) begin
         // R6
         grp_ripple_chk: assert (c_child[i+1] == (g_in[i] | (p_in[i] & c_child[i])))
            else $error("member carry disagrees with ripple");
      end
      // R6
      grp_cout_chk: assert ((g_out | (p_out & c_in)) ==
                            (g_in[K-1] | (p_in[K-1] & c_child[K-1])))
         else $error("group carry-out disagrees with member chain");
   end

endmodule

// File: rtl/cla_tree.sv
module cla_tree #(
   parameter int WIDTH = 64,
   parameter int GROUP = 4
) (
   input  logic [WIDTH-1:0] g_bit,
   input  logic [WIDTH-1:0] p_bit,
   input  logic             c_in,
   output logic [WIDTH-1:0] c_bit,
   output logic             c_out
);

   localparam int DEPTH = cla_pkg::tree_depth(WIDTH, GROUP);

   for (genvar l = 1; l <= DEPTH; l++) begin : lvl
      localparam int NN = cla_pkg::level_nodes(WIDTH, GROUP, l);
      localparam int NC = NN * GROUP;

      logic [NN-1:0] g_l;
      logic [NN-1:0] p_l;
      logic [NN-1:0] c_l;
      logic [NC-1:0] g_ch;
      logic [NC-1:0] p_ch;
      logic [NC-1:0] c_ch;

      // children of this level: bit terms at the bottom, the level below otherwise
      if (l == 1) begin : src
         assign g_ch  = g_bit;
         assign p_ch  = p_bit;
         assign c_bit = c_ch;
      end else begin : src
         assign g_ch = lvl[l-1].g_l;
         assign p_ch = lvl[l-1].p_l;
      end

      // carries into this level's nodes: block carry-in at the root
      if (l == DEPTH) begin : cfeed
         assign c_l = c_in;
      end else begin : cfeed
         assign c_l = lvl[l+1].c_ch;
      end

      for (genvar j = 0; j < NN; j++) begin : node
         cla_group #(.K(GROUP)) u_grp (
            .g_in    (g_ch[j*GROUP +: GROUP]),
            .p_in    (p_ch[j*GROUP +: GROUP]),
            .c_in    (c_l[j]),
            .g_out   (g_l[j]),
            .p_out   (p_l[j]),
            .c_child (c_ch[j*GROUP +: GROUP])
         );
      end
   end

   assign c_out = lvl[DEPTH].g_l[0] | (lvl[DEPTH].p_l[0] & c_in);

endmodule

// File: rtl/cla_sum.sv
module cla_sum #(
   parameter int WIDTH = 64
) (
   input  logic [WIDTH-1:0] gen_bits,
   input  logic [WIDTH-1:0] prop_bits,
   input  logic [WIDTH-1:0] carry_bits,
   output logic [WIDTH-1:0] sum_bits
);

   // with G = a&b and P = a|b, P ^ G equals a ^ b
   for (genvar j = 0; j < WIDTH; j++) begin : bit_sum
      assign sum_bits[j] = prop_bits[j] ^ gen_bits[j] ^ carry_bits[j];
   end

endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
   parameter int WIDTH = 64,
   parameter int GROUP = 4
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             sub_en,
   input  logic             carry_in,
   output logic [WIDTH-1:0] sum_out,
   output logic             carry_out,
   output logic             ovf_out
);

   localparam int MSB = WIDTH - 1;

   // R8: elaboration-time parameter checks
   if (!(WIDTH == 16 || WIDTH == 32 || WIDTH == 64)) begin : bad_width
      $error("WIDTH must be 16, 32 or 64");
   end
   if (!(GROUP == 2 || GROUP == 4)) begin : bad_group
      $error("GROUP must be 2 or 4");
   end
   if (!cla_pkg::is_power_of(WIDTH, GROUP)) begin : bad_ratio
      $error("WIDTH must be a power of GROUP");
   end

   logic [WIDTH-1:0] b_eff;
   logic             c_first;
   logic [WIDTH-1:0] g_bit;
   logic [WIDTH-1:0] p_bit;
   logic [WIDTH-1:0] c_bit;

   assign b_eff   = op_b ^ {WIDTH{sub_en}};
   assign c_first = sub_en | carry_in;

   cla_pg_bits #(.WIDTH(WIDTH)) u_pg (
      .a_bits    (op_a),
      .b_bits    (b_eff),
      .gen_bits  (g_bit),
      .prop_bits (p_bit)
   );

   cla_tree #(.WIDTH(WIDTH), .GROUP(GROUP)) u_tree (
      .g_bit (g_bit),
      .p_bit (p_bit),
      .c_in  (c_first),
      .c_bit (c_bit),
      .c_out (carry_out)
   );

   cla_sum #(.WIDTH(WIDTH)) u_sum (
      .gen_bits   (g_bit),
      .prop_bits  (p_bit),
      .carry_bits (c_bit),
      .sum_bits   (sum_out)
   );

   assign ovf_out = (op_a[MSB] ~^ b_eff[MSB]) & (sum_out[MSB] ^ op_a[MSB]);

   logic [WIDTH:0] ref_u;
   logic [WIDTH:0] ref_s;
   always_comb begin
      ref_u = {1'b0, op_a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, c_first};
      ref_s = {op_a[MSB], op_a} + {b_eff[MSB], b_eff} + {{WIDTH{1'b0}}, c_first};
      // R1
      add_result_chk: assert ({carry_out, sum_out} == ref_u)
         else $error("tree result differs from wide sum");
      // R4
      ovf_flag_chk: assert (ovf_out == (ref_s[WIDTH] ^ ref_s[MSB]))
         else $error("overflow flag differs from extended sign");
      // R3
      no_borrow_chk: assert (!sub_en || (carry_out == (op_a >= op_b)))
         else $error("borrow indication wrong");
   end

endmodule

// File: tb/tb_cla_adder.sv
module tb_cla_adder;

   localparam int W1 = 64;
   localparam int W2 = 32;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic [W1-1:0] a1, b1, s1;
   logic          sub1, cin1, co1, ov1;
   logic [W2-1:0] a2, b2, s2;
   logic          sub2, cin2, co2, ov2;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   cla_adder #(.WIDTH(W1), .GROUP(4)) dut (
      .op_a(a1), .op_b(b1), .sub_en(sub1), .carry_in(cin1),
      .sum_out(s1), .carry_out(co1), .ovf_out(ov1)
   );

   cla_adder #(.WIDTH(W2), .GROUP(2)) dut_k2 (
      .op_a(a2), .op_b(b2), .sub_en(sub2), .carry_in(cin2),
      .sum_out(s2), .carry_out(co2), .ovf_out(ov2)
   );

   function automatic logic [63:0] wmask(input int w);
      return (w == 64) ? {64{1'b1}} : ((64'h1 << w) - 64'h1);
   endfunction

   // expected {ovf, cout, sum} from the requirements
   function automatic logic [65:0] model(input logic [63:0] x, input logic [63:0] y,
                                         input logic sb, input logic ci, input int w);
      logic [63:0] m, xm, ye;
      logic [64:0] t;
      logic        c0, ovf;
      logic signed [65:0] sx, sy, r, lim;
      m  = wmask(w);
      xm = x & m;
      ye = (sb ? ~y : y) & m;
      c0 = sb ? 1'b1 : ci;
      t  = {1'b0, xm} + {1'b0, ye} + {64'b0, c0};
      sx = $signed({2'b00, xm});
      sy = $signed({2'b00, y & m});
      if (xm[w-1])       sx = sx - (66'sd1 <<< w);
      if ((y & m) >> (w-1) != 0) sy = sy - (66'sd1 <<< w);
      r   = sb ? (sx - sy) : (sx + sy + $signed({65'b0, ci}));
      lim = 66'sd1 <<< (w - 1);
      ovf = (r > lim - 66'sd1) || (r < -lim);
      return {ovf, t[w], t[63:0] & m};
   endfunction

   task automatic run(input string req, input bit big, input logic [63:0] x,
                      input logic [63:0] y, input logic sb, input logic ci);
      logic [65:0] act, exp;
      @(negedge clk);
      if (big) begin
         a1 = x; b1 = y; sub1 = sb; cin1 = ci;
      end else begin
         a2 = x[W2-1:0]; b2 = y[W2-1:0]; sub2 = sb; cin2 = ci;
      end
      #1;
      exp = model(x, y, sb, ci, big ? W1 : W2);
      act = big ? {ov1, co1, s1} : {ov2, co2, 32'b0, s2};
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s w=%0d: got ovf/co/sum %h expected %h", req,
                  big ? W1 : W2, act, exp);
      end
   endtask

   task automatic directed(input bit big);
      int w;
      logic [63:0] m, msb, alt;
      w   = big ? W1 : W2;
      m   = wmask(w);
      msb = 64'h1 << (w - 1);
      alt = 64'h5555_5555_5555_5555 & m;
      run("R1 all-zero inputs", big, 64'h0, 64'h0, 1'b0, 1'b0);
      run("R1 small add", big, 64'd1234, 64'd4321, 1'b0, 1'b1);
      run("R5 full-width carry", big, m, 64'h0, 1'b0, 1'b1);
      run("R5 all-ones plus one", big, m, 64'h1, 1'b0, 1'b0);
      run("R5 all-ones plus all-ones", big, m, m, 1'b0, 1'b1);
      run("R6 alternating no carry", big, alt, ~alt & m, 1'b0, 1'b0);
      run("R6 alternating full carry", big, alt, ~alt & m, 1'b0, 1'b1);
      run("R6 alternating doubled", big, alt, alt, 1'b0, 1'b0);
      run("R4 positive overflow", big, msb - 64'h1, 64'h1, 1'b0, 1'b0);
      run("R4 negative overflow", big, msb, msb, 1'b0, 1'b0);
      run("R4 sub overflow low", big, msb, 64'h1, 1'b1, 1'b0);
      run("R4 sub overflow high", big, 64'h0, msb, 1'b1, 1'b0);
      run("R3 equal operands", big, 64'd77, 64'd77, 1'b1, 1'b0);
      run("R3 borrow", big, 64'd3, 64'd5, 1'b1, 1'b0);
      run("R3 max minus zero", big, m, 64'h0, 1'b1, 1'b0);
      run("R2 cin low in sub", big, 64'd900, 64'd33, 1'b1, 1'b0);
      run("R2 cin high ignored", big, 64'd900, 64'd33, 1'b1, 1'b1);
   endtask

   initial begin
      a1 = '0; b1 = '0; sub1 = 1'b0; cin1 = 1'b0;
      a2 = '0; b2 = '0; sub2 = 1'b0; cin2 = 1'b0;
      void'($urandom(32'd24681357));

      // R8: both configurations run the same directed corner cases
      directed(1'b1);
      directed(1'b0);

      // R7: new pattern mid-cycle, sampled before any rising edge
      @(posedge clk);
      #0.5;
      a1 = 64'hFFFF_0000_FFFF_0000; b1 = 64'h0001_0000_0001_0000;
      sub1 = 1'b0; cin1 = 1'b0;
      #1;
      n_chk++;
      if ({co1, s1} !== 65'h1_0000_0001_0000_0000) begin
         n_bad++;
         $display("FAIL R7 no-clock update: got %h expected %h", {co1, s1},
                  65'h1_0000_0001_0000_0000);
      end

      for (int i = 0; i < 600; i++) begin
         logic [63:0] x, y;
         logic sb, ci;
         int sel;
         x   = {$urandom, $urandom};
         y   = {$urandom, $urandom};
         sb  = $urandom_range(0, 1) == 1;
         ci  = $urandom_range(0, 1) == 1;
         sel = $urandom_range(0, 7);
         if (sel == 0) y = x;
         if (sel == 1) y = ~x;
         if (sel == 2) x = {1'b0, {63{1'b1}}} ^ {32'b0, $urandom_range(0, 15)};
         run(sb ? "R2 random sub" : "R1 random add", 1'b1, x, y, sb, ci);
         run(sb ? "R2 random sub (R8 k2)" : "R1 random add (R8 k2)",
             1'b0, x, y, sb, ci);
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule